// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block is the per-core coherence controller for a small direct-mapped, write-back private cache. Each line holds one of three coherence states: Invalid, Shared or Modified. The processor side issues loads and stores and holds each request until the controller answers with ready. Local hits finish in the same cycle. Misses, upgrades and dirty evictions go out as transactions on a shared broadcast bus. Each transaction uses a request/grant handshake. Line fills come back as one whole block.

The same controller watches the transactions of the other cores on the bus. A read miss from another core that hits a Modified line here makes this cache supply the block. The memory response for that miss is then cancelled, and the local copy drops to Shared. A write miss or an invalidate from another core removes the local copy. If that copy is dirty, the controller supplies it first.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A load that hits a Shared or Modified line, or a store that hits a Modified line, raises `cpu_ready` in the cycle the request is seen with no snoop hit. It starts no bus transaction. The load data is the addressed 32-bit word of the line.
- R2: A load miss issues command 1 (read miss) with `bus_addr` = `cpu_addr[31:4]`. The line is then filled from `fill_data` and becomes Shared. A store miss issues command 2 (write miss) and the line becomes Modified. In both cases the request completes after the fill, which arrives with a one-cycle `fill_valid` pulse. Word k of a block sits at bits [32k+31:32k].
- R3: A miss whose line holds a Modified block with another tag first issues command 4 (write-back). That command carries the victim block address and the victim block on `bus_wdata`. The read or write miss for the new address follows.
- R4: A store that hits a Shared line issues command 3 (invalidate) with no fill. The line becomes Modified and the store then completes.
- R5: A snooped read miss (`snp_cmd` 1) to a Modified line raises `snp_flush` in the same cycle, with the line on `snp_data`. The line then becomes Shared.
- R6: A snooped write miss (`snp_cmd` 2) or invalidate (`snp_cmd` 3) to a Shared line makes it Invalid, with no flush. A snooped write miss to a Modified line flushes the block and makes it Invalid.
- R7: A snooped read miss to a Shared line leaves it Shared and raises no flush.
- R8: A snoop has no effect unless its block address matches both the tag and the index of a line that is not Invalid.
- R9: `cpu_ready` is low whenever `bus_req` is high. It is high only while `cpu_req` is high. It is low after reset.
- R10: When a snoop hits a valid line, `cpu_ready` stays low in that cycle. The snoop's state change takes effect first, and the processor request is then evaluated against the updated state.
- R11: Once raised, `bus_req` stays high with an unchanged `bus_cmd` until `bus_gnt`, provided no snoop hits a line in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with ready |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction pending |
| bus_gnt | input | 1 | Bus grant; the transaction is issued in this cycle |
| bus_cmd | output | 3 | 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr | output | AW-OB | Block address of the transaction |
| bus_wdata | output | WORDS*32 | Block carried by a write-back |
| fill_valid | input | 1 | Fill block present |
| fill_data | input | WORDS*32 | Fill block |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 3 | 1 read miss, 2 write miss, 3 invalidate |
| snp_addr | input | AW-OB | Snooped block address |
| snp_flush | output | 1 | This cache supplies the block; memory response is cancelled |
| snp_data | output | WORDS*32 | Supplied block |

## Verification
The bench uses the default geometry: 16 lines of four 32-bit words and 32-bit addresses. With this geometry, byte addresses 0x10 and 0x110 share index 1. That aliasing makes dirty replacement reachable, and so are snoops that match the index but not the tag. The four-word line lets stores to word offsets 1 and 2 show that the write-back and the flush carry whole blocks, not just the word being accessed. Every grant is delayed by one cycle so that the held request and its command can be observed.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int AW    = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [AW-1:0]           cpu_addr,
  input  logic [31:0]             cpu_wdata,
  output logic [31:0]             cpu_rdata,
  output logic                    cpu_ready,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [2:0]              bus_cmd,
  output logic [AW-$clog2(WORDS)-3:0] bus_addr,
  output logic [WORDS*32-1:0]     bus_wdata,
  input  logic                    fill_valid,
  input  logic [WORDS*32-1:0]     fill_data,
  input  logic                    snp_valid,
  input  logic [2:0]              snp_cmd,
  input  logic [AW-$clog2(WORDS)-3:0] snp_addr,
  output logic                    snp_flush,
  output logic [WORDS*32-1:0]     snp_data
);
  localparam int WS = $clog2(WORDS);
  localparam int OB = WS + 2;
  localparam int IB = $clog2(LINES);
  localparam int TB = AW - OB - IB;
  localparam int LW = WORDS * 32;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [2:0] C_NONE = 3'd0, C_RD = 3'd1, C_WR = 3'd2, C_INV = 3'd3, C_WB = 3'd4;
  localparam logic [1:0] F_IDLE = 2'd0, F_REQ = 2'd1, F_FILL = 2'd2;

  logic [1:0]    st_q  [LINES];
  logic [TB-1:0] tag_q [LINES];
  logic [LW-1:0] dat_q [LINES];
  logic [1:0]    fsm_q;

  wire [IB-1:0] c_idx  = cpu_addr[OB+IB-1:OB];
  wire [TB-1:0] c_tag  = cpu_addr[AW-1:OB+IB];
  wire [WS-1:0] c_wsel = cpu_addr[OB-1:2];
  wire [1:0]    c_st   = st_q[c_idx];
  wire          c_tmatch = (tag_q[c_idx] == c_tag);
  wire          c_hit  = c_tmatch && (c_st != ST_I);
  wire          c_ok   = c_hit && (!cpu_we || c_st == ST_M);

  wire [IB-1:0] s_idx = snp_addr[IB-1:0];
  wire [TB-1:0] s_tag = snp_addr[TB+IB-1:IB];
  wire [1:0]    s_st  = st_q[s_idx];
  wire          s_cmd_ok = (snp_cmd == C_RD) || (snp_cmd == C_WR) || (snp_cmd == C_INV);
  wire          s_hit = snp_valid && s_cmd_ok && (s_st != ST_I) && (tag_q[s_idx] == s_tag);

  logic unused_ok;
  assign unused_ok = ^cpu_addr[1:0];

  assign snp_flush = s_hit && (s_st == ST_M) && (snp_cmd != C_INV);
  assign snp_data  = dat_q[s_idx];
  assign cpu_ready = (fsm_q == F_IDLE) && cpu_req && c_ok && !s_hit;
  assign cpu_rdata = dat_q[c_idx][{c_wsel, 5'b0} +: 32];
  assign bus_req   = (fsm_q == F_REQ);
  assign bus_wdata = dat_q[c_idx];

  always_comb begin
    if (!bus_req)                                       bus_cmd = C_NONE;
    else if (c_st == ST_M && !c_tmatch)                 bus_cmd = C_WB;
    else if (cpu_we && c_st == ST_S && c_tmatch)        bus_cmd = C_INV;
    else if (cpu_we)                                    bus_cmd = C_WR;
    else                                                bus_cmd = C_RD;
  end

  assign bus_addr = (bus_cmd == C_WB) ? {tag_q[c_idx], c_idx} : cpu_addr[AW-1:OB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q <= F_IDLE;
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      case (fsm_q)
        F_IDLE: if (cpu_req && !c_ok && !s_hit) fsm_q <= F_REQ;
        F_REQ: if (bus_gnt) begin
          case (bus_cmd)
            C_WB:  st_q[c_idx] <= ST_I;
            C_INV: begin st_q[c_idx] <= ST_M; fsm_q <= F_IDLE; end
            default: begin st_q[c_idx] <= ST_I; fsm_q <= F_FILL; end
          endcase
        end
        F_FILL: if (fill_valid) begin
          st_q[c_idx] <= cpu_we ? ST_M : ST_S;
          fsm_q <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
      if (s_hit) begin
        if (snp_cmd == C_RD) begin
          if (s_st == ST_M) st_q[s_idx] <= ST_S;
        end else begin
          st_q[s_idx] <= ST_I;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_ready && cpu_we) dat_q[c_idx][{c_wsel, 5'b0} +: 32] <= cpu_wdata;
    if (fsm_q == F_FILL && fill_valid) begin
      dat_q[c_idx] <= fill_data;
      tag_q[c_idx] <= c_tag;
    end
  end

  a_r9_ready_excludes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req);
  a_r9_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !s_hit) |=> (bus_req && $stable(bus_cmd)));
  a_r5_flush_downgrades: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_flush && snp_cmd == C_RD) |=> (st_q[$past(s_idx)] == ST_S));
  a_r6_snoop_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && snp_cmd != C_RD) |=> (st_q[$past(s_idx)] == ST_I));
  a_r2_fill_leaves_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_FILL && fill_valid) |=> (st_q[$past(c_idx)] != ST_I));
  a_r8_flush_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_valid);
endmodule

// File: tb/msi_snoop_ctrl_test.sv
module msi_snoop_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic cpu_ready, bus_req, bus_gnt = 0;
  logic [2:0] bus_cmd;
  logic [27:0] bus_addr;
  logic [127:0] bus_wdata, fill_data = 0, snp_data;
  logic fill_valid = 0, snp_valid = 0, snp_flush;
  logic [2:0] snp_cmd = 0;
  logic [27:0] snp_addr = 0;

  always #2 clk = ~clk;

  msi_snoop_ctrl uut (.clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_data(snp_data));

  int vectors = 0, miscompares = 0;
  logic [31:0] memw [logic [29:0]];
  logic [31:0] refw [logic [29:0]];
  logic [63:0] exp_q [$];

  function automatic logic [31:0] init_w(logic [29:0] wa);
    return 32'(wa) * 32'h9E3779B1 + 32'h1234;
  endfunction
  function automatic logic [31:0] mem_rd(logic [29:0] wa);
    return memw.exists(wa) ? memw[wa] : init_w(wa);
  endfunction
  function automatic logic [31:0] ref_rd(logic [29:0] wa);
    return refw.exists(wa) ? refw[wa] : init_w(wa);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exp_bus(logic [2:0] cmd, logic [31:0] a);
    logic [31:0] d;
    d = (cmd == 3'd4) ? ref_rd({a[31:4], 2'b00}) : 32'h0;
    exp_q.push_back({1'b0, cmd, a[31:4], d});
  endtask

  logic [2:0] first_cmd;
  bit seen = 0;
  int fill_cnt = 0;
  logic [27:0] fill_blk;

  always @(negedge clk) begin
    bus_gnt = 0;
    fill_valid = 0;
    if (cpu_req && cpu_ready && !cpu_we) begin
      if (exp_q.size() == 0) check("R1 unexpected read", {4'hA, 28'h0, cpu_rdata}, 64'h0);
      else check("R1/R2 read data", {4'hA, 28'h0, cpu_rdata}, exp_q.pop_front());
    end
    if (snp_flush)
      for (int k = 0; k < 4; k++) memw[{snp_addr, 2'(k)}] = snp_data[32*k +: 32];
    if (fill_cnt != 0) begin
      if (fill_cnt == 1) begin
        fill_valid = 1;
        for (int k = 0; k < 4; k++) fill_data[32*k +: 32] = mem_rd({fill_blk, 2'(k)});
      end
      fill_cnt--;
    end else if (bus_req) begin
      check("R9 ready low during bus request", {63'h0, cpu_ready}, 64'h0);
      if (!seen) begin
        seen = 1;
        first_cmd = bus_cmd;
      end else begin
        seen = 0;
        check("R11 command held until grant", {61'h0, bus_cmd}, {61'h0, first_cmd});
        bus_gnt = 1;
        if (exp_q.size() == 0)
          check("R2/R3/R4 unexpected bus cmd", {1'b0, bus_cmd, bus_addr, 32'h0}, 64'h0);
        else
          check("R2/R3/R4 bus transaction",
                {1'b0, bus_cmd, bus_addr, (bus_cmd == 3'd4) ? bus_wdata[31:0] : 32'h0},
                exp_q.pop_front());
        if (bus_cmd == 3'd4)
          for (int k = 0; k < 4; k++) memw[{bus_addr, 2'(k)}] = bus_wdata[32*k +: 32];
        if (bus_cmd == 3'd1 || bus_cmd == 3'd2) begin
          fill_cnt = 2;
          fill_blk = bus_addr;
        end
      end
    end
  end

  task automatic cpu_op(bit we, logic [31:0] a, logic [31:0] d);
    if (!we) exp_q.push_back({4'hA, 28'h0, ref_rd(a[31:2])});
    else refw[a[31:2]] = d;
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic snoop(logic [2:0] cmd, logic [31:0] a, bit exp_flush, string req);
    @(posedge clk); #1;
    snp_valid = 1; snp_cmd = cmd; snp_addr = a[31:4];
    @(negedge clk);
    check(req, {63'h0, snp_flush}, {63'h0, exp_flush});
    if (exp_flush) check(req, {32'h0, snp_data[31:0]}, {32'h0, ref_rd({a[31:4], 2'b00})});
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  localparam logic [31:0] A = 32'h10, B = 32'h110, C = 32'h20, F = 32'h50, E = 32'h40;

  task automatic run();
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset ready", {63'h0, cpu_ready}, 64'h0);
    check("R9 reset bus_req", {63'h0, bus_req}, 64'h0);
    check("R8 reset flush", {63'h0, snp_flush}, 64'h0);
    rst_n = 1;
    exp_bus(3'd1, A); cpu_op(0, A, 0);              // R2 read miss
    cpu_op(0, A, 0);                                // R1 read hit
    exp_bus(3'd3, A); cpu_op(1, A, 32'hCAFE0001);   // R4 upgrade
    cpu_op(0, A, 0);                                // R1
    cpu_op(1, A + 4, 32'hBEEF0002);                 // R1 store hit on Modified
    exp_bus(3'd4, A); exp_bus(3'd1, B); cpu_op(0, B, 0); // R3 dirty victim
    exp_bus(3'd1, A); cpu_op(0, A, 0);              // R3 data reached memory
    snoop(3'd1, A, 0, "R7 snoop read on shared");
    cpu_op(0, A + 4, 0);                            // R7 still valid
    snoop(3'd2, B, 0, "R8 tag mismatch");
    cpu_op(0, A, 0);                                // R8 still valid
    snoop(3'd3, A, 0, "R6 invalidate shared");
    exp_bus(3'd1, A); cpu_op(0, A, 0);              // R6 line gone
    exp_bus(3'd2, C); cpu_op(1, C, 32'h5150C0DE);   // R2 write miss
    snoop(3'd1, C, 1, "R5 flush on read miss");
    cpu_op(0, C, 0);                                // R5 line still valid
    exp_bus(3'd3, C); cpu_op(1, C + 8, 32'h0BADF00D); // R5 was downgraded to shared
    snoop(3'd2, C, 1, "R6 flush on write miss");
    exp_bus(3'd1, C); cpu_op(0, C + 8, 0);          // R6 invalid, data from flush
    exp_bus(3'd1, F); cpu_op(0, F, 0);
    snoop(3'd2, F, 0, "R6 write miss on shared");
    exp_bus(3'd1, F); cpu_op(0, F, 0);
    exp_bus(3'd2, E); cpu_op(1, E, 32'h77E00077);
    exp_bus(3'd1, E);
    exp_q.push_back({4'hA, 28'h0, ref_rd(E[31:2])});
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = 0; cpu_addr = E;
    snp_valid = 1; snp_cmd = 3'd2; snp_addr = E[31:4];
    @(negedge clk);
    check("R10 ready held during snoop hit", {63'h0, cpu_ready}, 64'h0);
    check("R10 flush before processor", {63'h0, snp_flush}, 64'h1);
    @(posedge clk); #1;
    snp_valid = 0;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1;
    cpu_req = 0;
    repeat (4) @(posedge clk);
    check("R2 scoreboard drained", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule